// File: doc/BRIEF.md
# Per-Core Reset Type Sequencer

This block runs the reset of one core. One copy is placed next to each core. A controller raises a request together with a two-bit type code. The block then drives the core's active-low resets for the CPU, the debug logic, the trace unit and the watchdog flag, along with clock-off controls for the CPU, debug and trace clocks. It moves them in the order that the chosen reset type needs.

Power-up and software resets hold their resets for a long interval. They then stop the core clocks, release the resets while the clocks are stopped, and restart the clocks. As a result, every flop in the core leaves reset on the same clock edge. A software reset keeps the debug and trace state, because it never touches those resets. A debug reset pulses only the debug reset and leaves all clocks running. A watchdog-flag clear pulses only the watchdog-flag reset.

The block runs on a free-running clock. It shows `busy_o` while a sequence is in flight and pulses `done_o` at the end.

Top module: `core_rst_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a request is accepted, every reset output is high, every clock-off output is low, and `busy_o` and `done_o` are low.
- R2: When the block is idle, a high `req_i` is accepted on a rising edge. On that edge the block samples `req_type_i` (00 power-up, 01 software, 10 debug, 11 watchdog-flag clear), `req_wdog_i` and `trace_en_i`. `busy_o` is high from the next cycle through the `done_o` cycle, and is low otherwise.
- R3: The power-up sequence uses H = effective hold and S = effective settle. The CPU and debug resets are low for cycles 1 to H+S after acceptance. The CPU and debug clock-offs are high for cycles H+1 to H+2S. All resets are high from cycle H+S+1.
- R4: For power-up and software types, the watchdog-flag reset follows the CPU reset when the sampled watchdog bit is 1. When the bit is 0 it stays high.
- R5: For power-up with the trace bit sampled as 1, the trace reset and the trace clock-off equal the CPU reset and the CPU clock-off in every cycle. With the bit sampled as 0, both stay inactive.
- R6: The software type has the same timing as power-up. Its debug and trace resets and its trace clock-off stay inactive throughout.
- R7: The debug type drives only the debug reset low, for DBG_CYC cycles starting in cycle 1. All clock-offs stay low.
- R8: The watchdog-flag clear type drives only the watchdog-flag reset low, for WDF_CYC cycles starting in cycle 1. All other outputs stay inactive.
- R9: `done_o` is high for exactly one cycle, which is the cycle after the last active phase. All outputs are inactive in that cycle, and `busy_o` falls in the next cycle.
- R10: A request that arrives while `busy_o` is high, including in the `done_o` cycle, has no effect on any output and is not queued.
- R11: A hold or settle parameter below 10 is used as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| req_i | input | 1 | Start request |
| req_type_i | input | 2 | Reset type code |
| req_wdog_i | input | 1 | Also clear the watchdog flag (power-up and software types) |
| trace_en_i | input | 1 | The core's trace unit is present and enabled |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| cpu_rst_n_o | output | 1 | Core CPU reset, active low |
| dbg_rst_n_o | output | 1 | Core debug reset, active low |
| trc_rst_n_o | output | 1 | Core trace reset, active low |
| wdf_rst_n_o | output | 1 | Watchdog-flag reset, active low |
| cpu_clk_off_o | output | 1 | Stop the CPU clock |
| dbg_clk_off_o | output | 1 | Stop the debug clock |
| trc_clk_off_o | output | 1 | Stop the trace clock |

## Verification
Every output is a register loaded from the next-state decode, so a wrong phase or a wrong captured type appears at the pins in the very next cycle. The bench compares all nine outputs against a predicted waveform in every cycle.

A phase counter that is off by one moves the clock-off rising edge or the reset release by a single cycle, and the next comparison catches it. A type decode that is wrong asserts a reset that must stay high, for example the debug reset during a software reset. Spurious requests during a sequence are checked the same way, because any acceptance would change outputs that the waveform still predicts.

// File: rtl/core_rst_pkg.sv
package core_rst_pkg;

    typedef enum logic [1:0] {
        RK_PWRUP = 2'b00,
        RK_SOFT  = 2'b01,
        RK_DEBUG = 2'b10,
        RK_WDCLR = 2'b11
    } rst_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HOLD = 3'd1,
        PH_GATE = 3'd2,
        PH_OPEN = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        rst_kind_e kind;
        logic      wdog;
        logic      trace;
    } ctx_t;

    typedef struct packed {
        logic cpu_rst_n;
        logic dbg_rst_n;
        logic trc_rst_n;
        logic wdf_rst_n;
        logic cpu_off;
        logic dbg_off;
        logic trc_off;
    } pins_t;

    localparam pins_t PINS_QUIET = '{
        cpu_rst_n: 1'b1, dbg_rst_n: 1'b1, trc_rst_n: 1'b1, wdf_rst_n: 1'b1,
        cpu_off: 1'b0, dbg_off: 1'b0, trc_off: 1'b0
    };

    function automatic int unsigned floor_at(input int unsigned val, input int unsigned lo);
        return (val < lo) ? lo : val;
    endfunction

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          last_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CW'(1));

    // R3: a phase starts with the full length that was loaded
    p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));

    // R3: the count only ever moves down by one between loads
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rst_seq_decode.sv
module rst_seq_decode
    import core_rst_pkg::*;
(
    input  phase_e phase_i,
    input  ctx_t   ctx_i,
    output pins_t  pins_o
);

    logic in_reset;
    logic gated;
    logic is_pwrup;

    assign in_reset = (phase_i == PH_HOLD) || (phase_i == PH_GATE);
    assign gated    = (phase_i == PH_GATE) || (phase_i == PH_OPEN);
    assign is_pwrup = (ctx_i.kind == RK_PWRUP);

    always_comb begin
        pins_o = PINS_QUIET;
        unique case (ctx_i.kind)
            RK_PWRUP, RK_SOFT: begin
                if (in_reset) begin
                    pins_o.cpu_rst_n = 1'b0;
                    pins_o.wdf_rst_n = !ctx_i.wdog;
                    if (is_pwrup) begin
                        pins_o.dbg_rst_n = 1'b0;
                        pins_o.trc_rst_n = !ctx_i.trace;
                    end
                end
                if (gated) begin
                    pins_o.cpu_off = 1'b1;
                    pins_o.dbg_off = 1'b1;
                    pins_o.trc_off = is_pwrup && ctx_i.trace;
                end
            end
            RK_DEBUG: begin
                if (phase_i == PH_HOLD) begin
                    pins_o.dbg_rst_n = 1'b0;
                end
            end
            RK_WDCLR: begin
                if (phase_i == PH_HOLD) begin
                    pins_o.wdf_rst_n = 1'b0;
                end
            end
            default: pins_o = PINS_QUIET;
        endcase
    end

endmodule

// File: rtl/core_rst_seq.sv
module core_rst_seq
    import core_rst_pkg::*;
#(
    parameter int unsigned HOLD_CYC   = 10,
    parameter int unsigned SETTLE_CYC = 10,
    parameter int unsigned DBG_CYC    = 10,
    parameter int unsigned WDF_CYC    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [1:0] req_type_i,
    input  logic       req_wdog_i,
    input  logic       trace_en_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       cpu_rst_n_o,
    output logic       dbg_rst_n_o,
    output logic       trc_rst_n_o,
    output logic       wdf_rst_n_o,
    output logic       cpu_clk_off_o,
    output logic       dbg_clk_off_o,
    output logic       trc_clk_off_o
);

    localparam int unsigned HOLD_EFF   = floor_at(HOLD_CYC, 10);
    localparam int unsigned SETTLE_EFF = floor_at(SETTLE_CYC, 10);
    localparam int unsigned DBG_EFF    = floor_at(DBG_CYC, 1);
    localparam int unsigned WDF_EFF    = floor_at(WDF_CYC, 1);
    localparam int unsigned MAX_A      = (HOLD_EFF > SETTLE_EFF) ? HOLD_EFF : SETTLE_EFF;
    localparam int unsigned MAX_B      = (DBG_EFF > WDF_EFF) ? DBG_EFF : WDF_EFF;
    localparam int unsigned MAX_LEN    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW         = $clog2(MAX_LEN + 1);

    localparam logic [CW-1:0] LEN_HOLD   = CW'(HOLD_EFF);
    localparam logic [CW-1:0] LEN_SETTLE = CW'(SETTLE_EFF);
    localparam logic [CW-1:0] LEN_DBG    = CW'(DBG_EFF);
    localparam logic [CW-1:0] LEN_WDF    = CW'(WDF_EFF);

    typedef struct packed {
        phase_e phase;
        ctx_t   ctx;
        logic   done;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    pins_t         pins_d, pins_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;

    rst_seq_timer #(.CW(CW)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .last_o    (tmr_last)
    );

    // Decode from the next state so the output flops line up with ctl_q.
    rst_seq_decode i_decode (
        .phase_i(ctl_d.phase),
        .ctx_i  (ctl_d.ctx),
        .pins_o (pins_d)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    ctl_d.ctx.kind  = rst_kind_e'(req_type_i);
                    ctl_d.ctx.wdog  = req_wdog_i;
                    ctl_d.ctx.trace = trace_en_i;
                    ctl_d.phase     = PH_HOLD;
                    tmr_load        = 1'b1;
                    unique case (rst_kind_e'(req_type_i))
                        RK_DEBUG: tmr_val = LEN_DBG;
                        RK_WDCLR: tmr_val = LEN_WDF;
                        default:  tmr_val = LEN_HOLD;
                    endcase
                end
            end
            PH_HOLD: begin
                if (tmr_last) begin
                    if (ctl_q.ctx.kind == RK_PWRUP || ctl_q.ctx.kind == RK_SOFT) begin
                        ctl_d.phase = PH_GATE;
                        tmr_load    = 1'b1;
                        tmr_val     = LEN_SETTLE;
                    end else begin
                        ctl_d.phase = PH_DONE;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            PH_GATE: begin
                if (tmr_last) begin
                    ctl_d.phase = PH_OPEN;
                    tmr_load    = 1'b1;
                    tmr_val     = LEN_SETTLE;
                end
            end
            PH_OPEN: begin
                if (tmr_last) begin
                    ctl_d.phase = PH_DONE;
                    ctl_d.done  = 1'b1;
                end
            end
            PH_DONE: begin
                ctl_d.phase = PH_IDLE;
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '{phase: PH_IDLE, ctx: '0, done: 1'b0};
            pins_q <= PINS_QUIET;
        end else begin
            ctl_q  <= ctl_d;
            pins_q <= pins_d;
        end
    end

    assign busy_o        = (ctl_q.phase != PH_IDLE);
    assign done_o        = ctl_q.done;
    assign cpu_rst_n_o   = pins_q.cpu_rst_n;
    assign dbg_rst_n_o   = pins_q.dbg_rst_n;
    assign trc_rst_n_o   = pins_q.trc_rst_n;
    assign wdf_rst_n_o   = pins_q.wdf_rst_n;
    assign cpu_clk_off_o = pins_q.cpu_off;
    assign dbg_clk_off_o = pins_q.dbg_off;
    assign trc_clk_off_o = pins_q.trc_off;

    // R3: the CPU reset is only ever released while its clock is stopped
    p_release_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n_o) |-> cpu_clk_off_o);

    // R5: trace pins shadow the CPU pins in a traced power-up
    p_trace_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.ctx.kind == RK_PWRUP && ctl_q.ctx.trace)
        |-> (trc_rst_n_o == cpu_rst_n_o && trc_clk_off_o == cpu_clk_off_o));

    // R6: a software reset keeps debug and trace state
    p_soft_keeps_dbg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.ctx.kind == RK_SOFT)
        |-> (dbg_rst_n_o && trc_rst_n_o && !trc_clk_off_o));

    // R7: a debug reset never stops a clock or resets the CPU
    p_debug_no_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.ctx.kind == RK_DEBUG)
        |-> (!cpu_clk_off_o && !dbg_clk_off_o && !trc_clk_off_o && cpu_rst_n_o
             && trc_rst_n_o && wdf_rst_n_o));

    // R8: a watchdog-flag clear touches nothing else
    p_wdclr_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.ctx.kind == RK_WDCLR)
        |-> (cpu_rst_n_o && dbg_rst_n_o && trc_rst_n_o
             && !cpu_clk_off_o && !dbg_clk_off_o && !trc_clk_off_o));

    // R9: done lasts one cycle and busy falls right after it
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R10: requests while busy leave the captured context alone
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i) |=> $stable(ctl_q.ctx));

endmodule

// File: tb/test_core_rst_seq.sv
module test_core_rst_seq;

    localparam int unsigned HOLD_P   = 4;
    localparam int unsigned SETTLE_P = 12;
    localparam int unsigned DBG_P    = 6;
    localparam int unsigned WDF_P    = 3;
    // R11: values below 10 are used as 10
    localparam int unsigned H = (HOLD_P < 10) ? 10 : HOLD_P;
    localparam int unsigned S = (SETTLE_P < 10) ? 10 : SETTLE_P;

    // order: busy done cpu dbg trc wdf cpu_off dbg_off trc_off
    localparam logic [8:0] QUIET = 9'b0_0_1111_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] rtype = 2'b00;
    logic       wdog = 1'b0;
    logic       trc = 1'b0;
    logic       busy, done, cpu_n, dbg_n, trc_n, wdf_n, coff, doff, toff;

    int         checks = 0;
    int         errors = 0;
    int         pending = 0;
    logic       mon_en = 1'b0;
    logic       finished = 1'b0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    core_rst_seq #(
        .HOLD_CYC  (HOLD_P),
        .SETTLE_CYC(SETTLE_P),
        .DBG_CYC   (DBG_P),
        .WDF_CYC   (WDF_P)
    ) i_core_rst_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .req_type_i   (rtype),
        .req_wdog_i   (wdog),
        .trace_en_i   (trc),
        .busy_o       (busy),
        .done_o       (done),
        .cpu_rst_n_o  (cpu_n),
        .dbg_rst_n_o  (dbg_n),
        .trc_rst_n_o  (trc_n),
        .wdf_rst_n_o  (wdf_n),
        .cpu_clk_off_o(coff),
        .dbg_clk_off_o(doff),
        .trc_clk_off_o(toff)
    );

    function automatic logic [8:0] observed();
        return {busy, done, cpu_n, dbg_n, trc_n, wdf_n, coff, doff, toff};
    endfunction

    task automatic check(input string tag, input logic [8:0] exp);
        logic [8:0] got;
        got = observed();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic push(input logic [8:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        pending++;
    endtask

    // Scoreboard monitor: one expected vector per cycle, quiet when empty.
    always @(negedge clk) begin
        if (mon_en) begin
            logic [8:0] e;
            string      t;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                pending--;
            end else begin
                e = QUIET;
                t = "R2";
            end
            check(t, e);
        end
    end

    // Build the expected waveform of one accepted request.
    task automatic push_expect(input logic [1:0] k, input logic w, input logic tr,
                               input string force_tag);
        logic  pu, sw, r_cpu, r_dbg, r_trc, r_wdf, o_trc;
        string base;
        pu = (k == 2'b00);
        sw = (k == 2'b01);
        if (pu || sw) begin
            r_cpu = 1'b0;
            r_dbg = pu ? 1'b0 : 1'b1;
            r_trc = (pu && tr) ? 1'b0 : 1'b1;
            r_wdf = w ? 1'b0 : 1'b1;
            o_trc = pu && tr;
            if (force_tag != "")  base = force_tag;
            else if (pu && tr)    base = "R5";
            else if (w)           base = "R4";
            else if (pu)          base = "R3";
            else                  base = "R6";
            for (int i = 0; i < H; i++)
                push({2'b10, r_cpu, r_dbg, r_trc, r_wdf, 3'b000}, base);
            for (int i = 0; i < S; i++)
                push({2'b10, r_cpu, r_dbg, r_trc, r_wdf, 2'b11, o_trc},
                     (i == 0) ? "R11" : base);
            for (int i = 0; i < S; i++)
                push({2'b10, 4'b1111, 2'b11, o_trc}, base);
        end else if (k == 2'b10) begin
            for (int i = 0; i < DBG_P; i++)
                push({2'b10, 4'b1011, 3'b000}, "R7");
        end else begin
            for (int i = 0; i < WDF_P; i++)
                push({2'b10, 4'b1110, 3'b000}, "R8");
        end
        push({2'b11, 4'b1111, 3'b000}, "R9");
    endtask

    task automatic run_req(input logic [1:0] k, input logic w, input logic tr,
                           input logic spurious);
        @(negedge clk);
        #1;
        req   = 1'b1;
        rtype = k;
        wdog  = w;
        trc   = tr;
        push_expect(k, w, tr, spurious ? "R10" : "");
        @(negedge clk);
        #1;
        req   = 1'b0;
        rtype = ~k;
        wdog  = ~w;
        trc   = ~tr;
        if (spurious) begin
            // R10: requests in mid-sequence, in the last active cycle and in the done cycle
            repeat (3) @(negedge clk);
            #1;
            req   = 1'b1;
            rtype = 2'b11;
            @(negedge clk);
            #1;
            req = 1'b0;
            wait (pending == 1);
            #1;
            req   = 1'b1;
            rtype = 2'b10;
            @(negedge clk);
            @(negedge clk);
            #1;
            req = 1'b0;
        end
        wait (pending == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", QUIET);
        req = 1'b1;
        @(negedge clk);
        check("R1", QUIET);
        #1;
        req   = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", QUIET);
        #1;
        mon_en = 1'b1;

        run_req(2'b00, 1'b0, 1'b0, 1'b0);  // R3 plain power-up
        run_req(2'b00, 1'b1, 1'b1, 1'b0);  // R4 and R5
        run_req(2'b01, 1'b0, 1'b1, 1'b0);  // R6 trace bit has no effect
        run_req(2'b01, 1'b1, 1'b0, 1'b0);  // R4 on software type
        run_req(2'b10, 1'b1, 1'b1, 1'b0);  // R7
        run_req(2'b11, 1'b0, 1'b1, 1'b0);  // R8
        run_req(2'b00, 1'b0, 1'b0, 1'b1);  // R10
        run_req(2'b10, 1'b0, 1'b0, 1'b0);  // R7 back to back
        run_req(2'b11, 1'b1, 1'b0, 1'b0);  // R8

        repeat (4) @(negedge clk);
        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, pending %0d expected 0", pending);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule